// File: doc/BRIEF.md
# Three-Cycle Trigger Pulse Controller

This block turns a single-bit trigger into an output pulse that stays high for exactly three clock cycles. With a 10 ns clock the pulse lasts 30 ns. The trigger is sampled on each rising clock edge. When the trigger is seen high while the controller is idle, the output goes high on that edge and stays high for three cycles.

The length of the pulse comes from a fixed chain of three distinct active states, not from a loadable counter. The controller is a Moore machine, so the output depends only on the registered state. Trigger activity during a pulse is ignored and never extends or restarts the pulse. A trigger held high past the end of a pulse starts a new pulse only after the controller has spent one cycle idle. Debouncing and synchronizing the trigger belong to the logic upstream.

Reset is asynchronous and active-low. It clears the controller at once. Its release is synchronized to the clock through a short flop chain.

Top module: `pulse_tmr`

## Requirements
- R1: While `rst_ni` is low, `pulse_o` is 0, and it drops to 0 without waiting for a clock edge when `rst_ni` falls during a pulse.
- R2: After `rst_ni` rises, the first RST_SYNC_STAGES (default 2) rising edges do not accept the trigger. The edge after those can start a pulse.
- R3: In the idle state, a rising edge with `trig_i` = 1 makes `pulse_o` 1 from that edge onward.
- R4: In the idle state, a rising edge with `trig_i` = 0 keeps `pulse_o` at 0.
- R5: A pulse lasts exactly three clock cycles. The third edge after the starting edge returns `pulse_o` to 0.
- R6: The value of `trig_i` at the first, second and third edges of a pulse has no effect on its length or on the cycle that follows it.
- R7: When `trig_i` stays at 1 continuously, `pulse_o` repeats the pattern of three cycles high and one cycle low. A new pulse begins only on an edge where the trigger is seen high while idle.
- R8: The state register uses a 2-bit encoding: idle=00, first=01, second=10, third=11. Every active state steps to the next one in that order with no condition, and the third returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all transitions happen on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_i | input | 1 | Trigger request, already synchronous to `clk_i` |
| pulse_o | output | 1 | Active-high output pulse, three cycles long |

## Verification
On every cycle the assertions check the following:
- the idle state responds to the trigger (start a pulse when it is high, stay idle when it is low);
- the fixed state chain runs with no condition, whatever the trigger does;
- the output matches the active states;
- the output stays low while reset is held.

Only the bench scenarios can show the following:
- the exact cycle at which the synchronized reset release lets the first trigger through;
- the immediate drop of the output when reset is asserted mid-pulse;
- the three-high, one-low rhythm under a trigger that stays high.

// File: rtl/pulse_tmr_pkg.sv
package pulse_tmr_pkg;
  localparam int unsigned ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 2'b00,
    ST_HI1  = 2'b01,
    ST_HI2  = 2'b10,
    ST_HI3  = 2'b11
  } tmr_state_e;
endpackage

// File: rtl/pulse_tmr_rst_sync.sv
module pulse_tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pulse_tmr_next.sv
module pulse_tmr_next
  import pulse_tmr_pkg::*;
(
  input  tmr_state_e state_i,
  input  logic       trig_i,
  output tmr_state_e state_d_o,
  output logic       load_en_o
);
  always_comb begin
    state_d_o = state_i;
    unique case (state_i)
      ST_IDLE: state_d_o = trig_i ? ST_HI1 : ST_IDLE;
      ST_HI1:  state_d_o = ST_HI2;
      ST_HI2:  state_d_o = ST_HI3;
      ST_HI3:  state_d_o = ST_IDLE;
      default: state_d_o = ST_IDLE;
    endcase
  end

  // The register only needs to load when the state will change.
  assign load_en_o = (state_i != ST_IDLE) | trig_i;
endmodule

// File: rtl/pulse_tmr_state_reg.sv
module pulse_tmr_state_reg
  import pulse_tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  tmr_state_e state_d_i,
  output tmr_state_e state_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q_o <= ST_IDLE;
    end else if (en_i) begin
      state_q_o <= state_d_i;
    end
  end
endmodule

// File: rtl/pulse_tmr_out.sv
module pulse_tmr_out
  import pulse_tmr_pkg::*;
(
  input  tmr_state_e state_i,
  output logic       pulse_o
);
  always_comb begin
    unique case (state_i)
      ST_HI1, ST_HI2, ST_HI3: pulse_o = 1'b1;
      default:                pulse_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pulse_tmr.sv
module pulse_tmr
  import pulse_tmr_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  logic       rst_n_sync;
  logic       load_en;
  tmr_state_e state_d;
  tmr_state_e state_q;

  pulse_tmr_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  pulse_tmr_next u_next (
    .state_i   (state_q),
    .trig_i    (trig_i),
    .state_d_o (state_d),
    .load_en_o (load_en)
  );

  pulse_tmr_state_reg u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .en_i      (load_en),
    .state_d_i (state_d),
    .state_q_o (state_q)
  );

  pulse_tmr_out u_out (
    .state_i (state_q),
    .pulse_o (pulse_o)
  );
endmodule

// File: rtl/pulse_tmr_chk.sv
module pulse_tmr_chk
  import pulse_tmr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rst_n_sync,
  input logic       trig_i,
  input logic       pulse_o,
  input tmr_state_e state_q
);
  // R1
  reset_low_chk: assert property (@(posedge clk_i) !rst_ni |-> !pulse_o);

  // R3
  idle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (state_q == ST_IDLE && trig_i) |=> (pulse_o && state_q == ST_HI1));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (state_q == ST_IDLE && !trig_i) |=> !pulse_o);

  // R8
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    state_q == ST_HI1 |=> state_q == ST_HI2);

  // R8
  step_two_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    state_q == ST_HI2 |=> state_q == ST_HI3);

  // R6
  step_end_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    state_q == ST_HI3 |=> (state_q == ST_IDLE && !pulse_o));

  // R5
  out_map_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    pulse_o == (state_q != ST_IDLE));
endmodule

bind pulse_tmr pulse_tmr_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_n_sync (rst_n_sync),
  .trig_i     (trig_i),
  .pulse_o    (pulse_o),
  .state_q    (state_q)
);

// File: tb/pulse_tmr_tb_top.sv
`timescale 1ns/1ps
module pulse_tmr_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic trig = 1'b0;
  logic pulse;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pulse_tmr dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .trig_i  (trig),
    .pulse_o (pulse)
  );

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (pulse !== exp) begin
      n_fail++;
      $display("FAIL %s: pulse_o=%b expected %b at %0t", req, pulse, exp, $time);
    end
  endtask

  // Drive the trigger at the falling edge, then sample 5 ns after the next rising edge.
  task automatic step(input string req, input logic t, input logic exp);
    @(negedge clk);
    trig = t;
    @(posedge clk);
    #5;
    check(req, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    trig = 1'b0;
    #1 check("R1", 1'b0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 4; i++) step("R4", 1'b0, 1'b0);
  endtask

  task automatic t_single();
    step("R3", 1'b1, 1'b1);
    step("R5", 1'b0, 1'b1);
    step("R5", 1'b0, 1'b1);
    step("R5", 1'b0, 1'b0);
    step("R4", 1'b0, 1'b0);
  endtask

  task automatic t_mid_trig();
    step("R3", 1'b1, 1'b1);
    step("R6", 1'b1, 1'b1);
    step("R6", 1'b1, 1'b1);
    step("R6", 1'b0, 1'b0);
    step("R6", 1'b0, 1'b0);
  endtask

  task automatic t_held();
    step("R3", 1'b1, 1'b1);
    step("R7", 1'b1, 1'b1);
    step("R7", 1'b1, 1'b1);
    step("R7", 1'b1, 1'b0);
    step("R7", 1'b1, 1'b1);
    step("R7", 1'b0, 1'b1);
    step("R7", 1'b0, 1'b1);
    step("R7", 1'b0, 1'b0);
  endtask

  task automatic t_reset_mid();
    step("R3", 1'b1, 1'b1);
    @(negedge clk);
    trig = 1'b0;
    #3 rst_ni = 1'b0;
    #1 check("R1", 1'b0);
    @(posedge clk);
    #5 check("R1", 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    trig = 1'b1;
    @(posedge clk);
    #5 check("R2", 1'b0);
    step("R2", 1'b1, 1'b0);
    step("R2", 1'b1, 1'b1);
    step("R5", 1'b0, 1'b1);
    step("R5", 1'b0, 1'b1);
    step("R5", 1'b0, 1'b0);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    #1 check("R1", 1'b0);
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_idle();
    t_single();
    t_mid_trig();
    t_held();
    t_reset_mid();
    do_reset();
    t_single();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule